// File: doc/BRIEF.md
# Selectable-Order Burst Address Sequencer

This block produces the address sequence for a four-beat burst into a synchronous burst memory. At a rising clock edge where either of two independent active-low load strobes is low, it registers a full start address. The upper bits are held in their own register and pass to the output unchanged for the whole burst. The low two bits become the burst start offset, and the internal beat index clears to zero.

After the load, each rising edge where the active-low advance input is low moves the beat index on by one, wrapping modulo four. Edges without advance leave everything as it is. The low two output bits are formed from the start offset and the beat index in one of two orders, chosen by a plain mode pin. In interleaved order the start offset is XORed with the beat index. In linear order the beat index is added to the start offset modulo four. A flag marks the fourth beat.

The interface has only plain control pins and a registered address. There is no data stream, so no valid/ready handshake is used and nothing stalls the block.

Top module: `burst_seq_gen`

## Requirements
- R1: On a rising edge where `lda_n` is low or `ldb_n` is low (or both are low), the block captures `addr_i`. From the next cycle, `addr_o[1:0]` equals the captured `addr_i[1:0]`, the beat index is 0, and `last_beat_o` is 0.
- R2: If a load and an advance (`step_n` low) occur on the same edge, the load wins. The beat index afterwards is 0, not 1.
- R3: With both strobes high, an edge where `step_n` is low increments the beat index by one. An edge where `step_n` is high leaves `addr_o` and `last_beat_o` unchanged, as long as `order_linear` does not change.
- R4: With `order_linear` = 0 (interleaved), `addr_o[1:0]` = start XOR beat. For example, start 2 gives the sequence 2,3,0,1, and start 1 gives 1,0,3,2.
- R5: With `order_linear` = 1 (linear), `addr_o[1:0]` = (start + beat) mod 4. For example, start 1 gives the sequence 1,2,3,0. `order_linear` acts combinationally on the current beat.
- R6: A fourth advance after a load returns the beat index to 0, so `addr_o[1:0]` equals the start offset again. No carry reaches `addr_o[ADDR_W-1:2]`.
- R7: `last_beat_o` is 1 exactly when the beat index is 3.
- R8: `addr_o[ADDR_W-1:2]` equals the upper bits captured at the last load. Advancing and holding do not change it.
- R9: While `rst_n` is low, and in the first cycle after it is released with no load, `addr_o` is 0 and `last_beat_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Start address, sampled on a load |
| lda_n | input | 1 | First load strobe, active low |
| ldb_n | input | 1 | Second load strobe, active low |
| step_n | input | 1 | Advance to the next beat, active low |
| order_linear | input | 1 | 1 selects linear order, 0 selects interleaved order |
| addr_o | output | ADDR_W | Current burst address |
| last_beat_o | output | 1 | High on the fourth beat |

## Verification
The hardest situation to reach is a wraparound that exposes a wrong order or a stray carry. It only shows after a load followed by at least four advances, with hold cycles in between, in both orders and from every start offset. The bench sweeps every combination of mode, start offset, load strobe and same-edge advance. Each burst runs six advances separated by idle cycles, so each beat is seen twice and the wrap is crossed. A final burst flips the mode pin mid-burst to show the order acts on the live beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [BEAT_W-1:0] start_i,
  output logic [BEAT_W-1:0] start_q,
  output logic [BEAT_W-1:0] beat_q
);
  localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      start_q <= start_i;
      beat_q  <= '0;
    end else if (adv) begin
      beat_q  <= beat_q + BEAT_ONE;
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              order_sel,
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] offset
);
  burst_order_e ord;

  always_comb begin
    ord = burst_order_e'(order_sel);
    unique case (ord)
      ORD_LINEAR:     offset = start + beat;
      ORD_INTERLEAVE: offset = start ^ beat;
      default:        offset = start ^ beat;
    endcase
  end
endmodule

// File: rtl/burst_upper_reg.sv
module burst_upper_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lda_n,
  input  logic              ldb_n,
  input  logic              step_n,
  input  logic              order_linear,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_beat_o
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic              load;
  logic              adv;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] offset;

  assign load = ~lda_n | ~ldb_n;
  assign adv  = ~step_n;

  burst_beat_ctr #(.BEAT_W(BEAT_W)) ctr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .adv     (adv),
    .start_i (addr_i[BEAT_W-1:0]),
    .start_q (start_q),
    .beat_q  (beat_q)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) map_i (
    .order_sel (order_linear),
    .start     (start_q),
    .beat      (beat_q),
    .offset    (offset)
  );

  generate
    if (UPPER_W > 0) begin : g_upper
      logic [UPPER_W-1:0] upper_q;
      burst_upper_reg #(.W(UPPER_W)) up_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (addr_i[ADDR_W-1:BEAT_W]),
        .q     (upper_q)
      );
      assign addr_o = {upper_q, offset};
    end else begin : g_no_upper
      assign addr_o = offset;
    end
  endgenerate

  assign last_beat_o = &beat_q;
endmodule

// File: rtl/burst_seq_gen_chk.sv
module burst_seq_gen_chk #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              lda_n,
  input logic              ldb_n,
  input logic              step_n,
  input logic              order_linear,
  input logic [ADDR_W-1:0] addr_o,
  input logic              last_beat_o
);
  logic any_load;
  assign any_load = !lda_n || !ldb_n;

  // R1, R2: a load sets the start offset and beat zero, even with an advance
  p_load_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    any_load |=> (addr_o[BEAT_W-1:0] == $past(addr_i[BEAT_W-1:0])) && !last_beat_o);

  // R3: idle edge with a stable mode keeps outputs
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lda_n && ldb_n && step_n) && $stable(order_linear))
      |-> ($stable(addr_o) && $stable(last_beat_o)));

  // R5, R6: linear advance adds one modulo four
  p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!step_n && lda_n && ldb_n && order_linear) && order_linear)
      |-> (addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + BEAT_W'(1))));

  // R8: upper bits follow the loaded address
  p_upper_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_load |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_i[ADDR_W-1:BEAT_W]));

  // R8: advancing leaves upper bits alone
  p_upper_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_load && !step_n) |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

  // R7: advancing past the fourth beat drops the flag
  p_last_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat_o && !step_n && !any_load) |=> !last_beat_o);

  // R9: outputs cleared in reset
  always_comb begin
    if (rst_n === 1'b0) begin
      a_reset_r9: assert (addr_o == '0 && last_beat_o == 1'b0);
    end
  end
endmodule

bind burst_seq_gen burst_seq_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_i       (addr_i),
  .lda_n        (lda_n),
  .ldb_n        (ldb_n),
  .step_n       (step_n),
  .order_linear (order_linear),
  .addr_o       (addr_o),
  .last_beat_o  (last_beat_o)
);

// File: tb/burst_seq_gen_tb_top.sv
module burst_seq_gen_tb_top;
  localparam int ADDR_W = 18;
  localparam int UW     = ADDR_W - 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] addr_i;
  logic              lda_n, ldb_n, step_n, order_linear;
  logic [ADDR_W-1:0] addr_o;
  logic              last_beat_o;

  int errors = 0;
  int checks = 0;

  // model state
  int          m_start, m_beat;
  logic [UW-1:0] m_upper;

  always #2 clk = ~clk;

  burst_seq_gen #(.ADDR_W(ADDR_W), .BEAT_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .lda_n(lda_n), .ldb_n(ldb_n),
    .step_n(step_n), .order_linear(order_linear), .addr_o(addr_o),
    .last_beat_o(last_beat_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_off(input int s, input int b, input logic lin);
    return lin ? ((s + b) % 4) : (s ^ b);
  endfunction

  // drive at negedge, apply edge, update model, check at next negedge
  task automatic cyc(input logic a_n, input logic b_n, input logic s_n,
                     input logic lin, input logic [ADDR_W-1:0] ad);
    int prev_beat;
    lda_n = a_n; ldb_n = b_n; step_n = s_n; order_linear = lin; addr_i = ad;
    @(posedge clk);
    prev_beat = m_beat;
    if (!a_n || !b_n) begin
      m_start = int'(ad[1:0]); m_beat = 0; m_upper = ad[ADDR_W-1:2];
    end else if (!s_n) begin
      m_beat = (m_beat + 1) % 4;
    end
    @(negedge clk);
    if (!a_n || !b_n) begin
      check(s_n ? "R1 load" : "R2 load beats advance", int'(addr_o[1:0]), m_start);
    end else if (s_n) begin
      check("R3 hold beat", m_beat, prev_beat);
    end
    check(lin ? "R5 linear offset" : "R4 interleaved offset",
          int'(addr_o[1:0]), exp_off(m_start, m_beat, lin));
    check("R7 last beat flag", int'(last_beat_o), (m_beat == 3) ? 1 : 0);
    check("R8 upper bits", int'(addr_o[ADDR_W-1:2]), int'(m_upper));
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lda_n = 1'b1; ldb_n = 1'b1; step_n = 1'b1;
    order_linear = 1'b0; addr_i = '0;
    m_start = 0; m_beat = 0; m_upper = '0;
    repeat (3) @(negedge clk);
    check("R9 reset addr", int'(addr_o), 0);
    check("R9 reset flag", int'(last_beat_o), 0);
    rst_n = 1'b1;
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 18'h3ffff);
    check("R9 idle after reset", int'(addr_o), 0);

    for (int lin = 0; lin < 2; lin++) begin
      for (int st = 0; st < 4; st++) begin
        for (int which = 0; which < 3; which++) begin
          for (int pri = 0; pri < 2; pri++) begin
            logic [ADDR_W-1:0] ad;
            ad = {UW'($urandom), 2'(st)};
            cyc(which == 1, which == 0, pri == 0, 1'(lin), ad);
            for (int k = 0; k < 6; k++) begin
              cyc(1'b1, 1'b1, 1'b1, 1'(lin), ~ad);
              cyc(1'b1, 1'b1, 1'b0, 1'(lin), ~ad);
              if (k == 3) check("R6 wrap to start", int'(addr_o[1:0]), st);
            end
          end
        end
      end
    end

    // mode flip mid-burst: start 1, two advances then change order
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 18'h2a5a1);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, '0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, '0);
    check("R4 start1 beat2 interleaved", int'(addr_o[1:0]), 3);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, '0);
    check("R5 start1 beat2 linear", int'(addr_o[1:0]), 3);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, '0);
    check("R5 start1 beat3 linear", int'(addr_o[1:0]), 0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, '0);
    check("R4 start1 beat3 interleaved", int'(addr_o[1:0]), 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule